// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, once per clock, whether a hart should take an interrupt at machine or supervisor level and which interrupt it is. It takes the pending, enable and delegation vectors, the current privilege level and the two global enable bits. It combines them into a set of surviving requests and picks the lowest-numbered one as the cause. The take flag and the cause number are registered, so they reach the trap logic one cycle after the inputs are presented.

Machine and supervisor requests are gated by different global enables. A request whose delegation bit is clear is a machine request; one whose delegation bit is set is a supervisor request. A global enable is always on when the hart runs below the level it guards, so a lower privilege can always be interrupted. Only the lines set in the `IMPL_MASK` parameter exist; the other lines are treated as zero in every input vector.

Top module: `irq_prio_sel`

## Requirements
- R1: A line is a candidate only when its pending bit, its enable bit and its `IMPL_MASK` bit are all set; with no candidate, `take_o` stays 0.
- R2: The machine-level global enable is on when the privilege is below M, or when the privilege is M and `mie_i` is 1; in M with `mie_i` at 0, no machine request is taken.
- R3: The supervisor-level global enable is on when the privilege is below S, or when the privilege is S and `sie_i` is 1; in M it is always off.
- R4: A candidate whose `deleg_i` bit is 0 survives only under the machine-level enable. A candidate whose `deleg_i` bit is 1 survives only under the supervisor-level enable.
- R5: When at least one candidate survives, `take_o` is 1 and `cause_o` is the index of the lowest-numbered surviving line.
- R6: When no candidate survives, `take_o` is 0 and `cause_o` is 0.
- R7: `priv_i` is encoded U=0, S=1, M=3; the value 2 behaves exactly like U.
- R8: Input bits outside `IMPL_MASK` (default 16'h0AAA, lines 1,3,5,7,9,11) have no effect on either output.
- R9: Outputs change one clock after the inputs; while `rst_ni` is 0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 16 | Pending interrupt lines |
| en_i | input | 16 | Per-line enables |
| deleg_i | input | 16 | Per-line delegation to supervisor level |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3, 2 as U) |
| mie_i | input | 1 | Machine global enable |
| sie_i | input | 1 | Supervisor global enable |
| take_o | output | 1 | Registered: an interrupt is to be taken |
| cause_o | output | 5 | Registered: cause number of the chosen line |

## Verification
All four privilege codes are swept against all four combinations of the two global enables, with sparse random pending, enable and delegation vectors. This separates errors in the privilege-dependent enables from errors in the delegation routing. Sparse vectors give many different lowest surviving indices, which tests the picker at every implemented line. Directed patterns place two requests on opposite sides of a delegation boundary, so a wrong gate chooses the wrong line. Other patterns drive only unimplemented lines, and others use privilege code 2, to show that these are ignored or aliased.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // Reserved code folds onto U
  function automatic priv_e norm_priv(logic [1:0] raw);
    return (raw == 2'd2) ? PRIV_U : priv_e'(raw);
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int unsigned          NUM_IRQ   = 16,
  parameter logic [NUM_IRQ-1:0]   IMPL_MASK = 16'h0AAA
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic [NUM_IRQ-1:0] cand_o,
  output logic [NUM_IRQ-1:0] surv_o
);
  priv_e priv;
  logic  m_on, s_on;

  always_comb begin
    priv   = norm_priv(priv_i);
    m_on   = (priv != PRIV_M) || mie_i;
    s_on   = (priv == PRIV_U) || ((priv == PRIV_S) && sie_i);
    cand_o = pend_i & en_i & IMPL_MASK;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign surv_o[g] = cand_o[g] & (deleg_i[g] ? s_on : m_on);
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NUM_IRQ = 16,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               valid_o,
  output logic [CAUSE_W-1:0] idx_o
);
  logic [NUM_IRQ-1:0] grant;

  always_comb begin
    grant   = req_i & (~req_i + NUM_IRQ'(1));
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) idx_o = idx_o | CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned        NUM_IRQ   = 16,
  parameter int unsigned        CAUSE_W   = 5,
  parameter logic [NUM_IRQ-1:0] IMPL_MASK = 16'h0AAA
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int unsigned MIN_CW = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] cand_w, surv_w;
  logic               hit_w;
  logic [CAUSE_W-1:0] idx_w;
  logic               primed_q;

  initial assert (CAUSE_W >= MIN_CW) else $error("cause width too small");

  irq_gate #(.NUM_IRQ(NUM_IRQ), .IMPL_MASK(IMPL_MASK)) u_gate (
    .pend_i (pend_i),
    .en_i   (en_i),
    .deleg_i(deleg_i),
    .priv_i (priv_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .cand_o (cand_w),
    .surv_o (surv_w)
  );

  irq_lowest_pick #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W)) u_pick (
    .req_i  (surv_w),
    .valid_o(hit_w),
    .idx_o  (idx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o   <= 1'b0;
      cause_o  <= '0;
      primed_q <= 1'b0;
    end else begin
      take_o   <= hit_w;
      cause_o  <= hit_w ? idx_w : '0;
      primed_q <= 1'b1;
    end
  end

  // Checks: primed_q keeps $past away from reset-time inputs
  assert_idle_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> cause_o == '0);

  assert_taken_is_candidate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && take_o) |-> ((($past(cand_w) >> cause_o) & NUM_IRQ'(1)) != '0));

  assert_lowest_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && take_o) |->
      (($past(surv_w) & ((NUM_IRQ'(1) << cause_o) - NUM_IRQ'(1))) == '0));

  assert_m_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(priv_i == 2'd3 && !mie_i)) |-> !take_o);

  assert_s_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(priv_i == 2'd1 && !sie_i && ((cand_w & ~deleg_i) == '0))) |-> !take_o);

  assert_user_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(priv_i[0] == 1'b0 && cand_w != '0)) |-> take_o);
endmodule

// File: tb/irq_prio_sel_test.sv
`timescale 1ns/1ps
module irq_prio_sel_test;
  localparam int N = 16;
  localparam logic [N-1:0] MASK = 16'h0AAA;

  logic clk = 0, rst_ni = 0;
  logic [N-1:0] pend, en, deleg;
  logic [1:0] priv;
  logic mie, sie;
  logic take;
  logic [4:0] cause;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_sel uut (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .mie_i(mie), .sie_i(sie), .take_o(take), .cause_o(cause)
  );

  // Reference from the requirements
  function automatic logic [5:0] model(logic [N-1:0] p, logic [N-1:0] e,
      logic [N-1:0] d, logic [1:0] pv, logic m, logic s);
    logic [N-1:0] c, sv;
    logic mon, son;
    int lvl;
    lvl = (pv == 2) ? 0 : pv;
    mon = (lvl < 3) || m;
    son = (lvl < 1) || (lvl == 1 && s);
    c   = p & e & MASK;
    sv  = (c & ~d & {N{mon}}) | (c & d & {N{son}});
    for (int i = 0; i < N; i++) if (sv[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic check(string req, logic [5:0] exp);
    checks++;
    if ({take, cause} !== exp) begin
      errors++;
      $display("FAIL %s: got take=%0b cause=%0d, expected take=%0b cause=%0d",
               req, take, cause, exp[5], exp[4:0]);
    end
  endtask

  task automatic apply(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
      logic [1:0] pv, logic m, logic s, string req);
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pv; mie = m; sie = s;
    @(negedge clk);
    check(req, model(p, e, d, pv, m, s));
  endtask

  initial begin
    pend = '1; en = '1; deleg = '0; priv = 0; mie = 1; sie = 1;
    repeat (3) @(negedge clk);
    check("R9 reset", 6'd0);
    rst_ni = 1;
    // R9: one-cycle latency
    @(negedge clk);
    pend = 16'h0008; en = '1; deleg = '0; priv = 3; mie = 1;
    checks++; if (take !== 1'b1 || cause !== 5'd1) begin errors++;
      $display("FAIL R9 pre-update: got %0b/%0d expected 1/1", take, cause); end
    @(negedge clk);
    check("R9 latency", 6'h23);
    // R1: pending without enable
    apply(16'h0AAA, 16'h0000, '0, 0, 1, 1, "R1 no enable");
    // R5: lowest index among two
    apply(16'h0208, 16'hFFFF, '0, 3, 1, 0, "R5 lowest");
    // R2: M with mie off
    apply(16'h0AAA, 16'hFFFF, '0, 3, 0, 1, "R2 M masked");
    // R3: S delegated in M never taken
    apply(16'h0020, 16'hFFFF, 16'h0020, 3, 1, 1, "R3 S off in M");
    // R4: delegated low line blocked, non-delegated higher line taken
    apply(16'h0220, 16'hFFFF, 16'h0020, 1, 1, 0, "R4 split");
    apply(16'h0220, 16'hFFFF, 16'h0020, 1, 1, 1, "R4 both open");
    // R7: code 2 behaves as U
    apply(16'h0080, 16'hFFFF, 16'h0080, 2, 0, 0, "R7 code2");
    // R8: unimplemented lines ignored
    apply(~MASK, 16'hFFFF, '0, 0, 1, 1, "R8 unimpl");
    apply(16'h0801 | 16'h0004, 16'hFFFF, '0, 0, 1, 1, "R8 mixed");
    // R6: idle
    apply('0, 16'hFFFF, '0, 0, 1, 1, "R6 idle");
    // Sweep: every privilege code and enable pair
    for (int pv = 0; pv < 4; pv++)
      for (int me = 0; me < 4; me++)
        for (int k = 0; k < 200; k++)
          apply(16'($urandom & $urandom), 16'($urandom | $urandom), 16'($urandom),
                2'(pv), me[1], me[0], "R2 R3 R4 R5 sweep");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk);
        errors++; $display("FAIL watchdog: got timeout, expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule